// File: doc/BRIEF.md
# Interrupt State Controller with Programmable Trigger Mode

This block collects a small set of interrupt request lines and gives each one a three-state life: Idle, Pending and Active. Every line has its own enable, trigger mode (edge or level) and priority. These are written through a simple one-source-at-a-time configuration port. Among the pending sources the block picks one winner and raises a single request output toward the processor.

The processor takes the interrupt with an acknowledge pulse. The identifier shown on the acknowledge port is the source that becomes Active on that clock edge. When the handler finishes, it ends the interrupt with a deactivate pulse that names the source.

The trigger mode decides what happens to a line that is still high when its interrupt is deactivated:

- A level source becomes pending again.
- An edge source waits for a new rising edge.

Because of this, a level-driven line that is configured as edge-triggered can be left asserted with no interrupt pending.

Top module: `irq_state_ctrl`

## Requirements
- R1: After reset every source is Idle and disabled, `irq` is low and `ack_id` shows the spurious code (all ones of the identifier width, 15 by default).
- R2: A configuration write to a source loads its enable, mode (`cfg_edge` 1 = edge, 0 = level) and priority. It also returns that source to Idle and discards any captured edge. Identifiers at or above the source count are ignored.
- R3: An Idle source that is enabled moves to Pending on the next edge when its trigger is seen. For level mode the trigger is the line being high. Pending persists until acknowledged. A disabled source ignores its line.
- R4: `irq` is high exactly when at least one source is Pending.
- R5: `ack_id` names the Pending source with the numerically lowest priority value, with ties going to the lower identifier. With nothing pending it shows the spurious code.
- R6: An `ack_rd` pulse moves the source shown on `ack_id` from Pending to Active. An acknowledge while nothing is pending changes no state.
- R7: A `deact_we` pulse naming an Active source ends its Active state. Naming a source that is not Active has no effect.
- R8: While a source is Active, its line staying high or changing does not alter its state. Only deactivation or configuration does.
- R9: In edge mode, a line held high through deactivation leaves the source Idle. Only a later 0-to-1 transition makes it Pending again.
- R10: In level mode, a source deactivated while its line is high is Idle for one cycle and Pending on the following edge.
- R11: In edge mode, a rising edge seen while the source is Active (including the deactivation cycle) is remembered. Deactivation then takes the source straight to Pending.
- R12: An edge is a line sampled high in a cycle after it was sampled low in the previous cycle. A line that is already high when edge mode is enabled does not trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line | input | NSRC | Interrupt request lines, one per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_id | input | ID_W | Source addressed by the configuration write |
| cfg_en | input | 1 | Enable value to load |
| cfg_edge | input | 1 | Trigger mode to load, 1 = edge, 0 = level |
| cfg_prio | input | PRIO_W | Priority to load, lower value wins |
| ack_rd | input | 1 | Acknowledge strobe |
| ack_id | output | ID_W | Current winning source, or spurious code |
| deact_we | input | 1 | Deactivate strobe |
| deact_id | input | ID_W | Source to deactivate |
| irq | output | 1 | Request toward the processor |

## Verification
The bench uses the defaults: eight sources, 4-bit priorities and a 4-bit identifier. With these widths the spurious code 15 is distinct from real identifiers, and the unused identifiers 8 to 14 can be driven on the configuration and deactivate ports to show they are ignored. Eight sources with sixteen priority levels are enough to produce priority ties and several pending sources at once. They also let the edge/level hazard be staged on one source while others stay busy.

// File: rtl/isc_pkg.sv
package isc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_ACT  = 2'd2
    } src_state_e;

endpackage

// File: rtl/isc_edge_detect.sv
module isc_edge_detect #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] line_i,
    output logic [NSRC-1:0] rise_o
);

    typedef struct packed {
        logic [NSRC-1:0] line;
    } ed_reg_t;

    ed_reg_t ed_d, ed_q;

    always_comb begin
        ed_d      = ed_q;
        ed_d.line = line_i;
        rise_o    = line_i & ~ed_q.line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ed_q <= '0;
        end else begin
            ed_q <= ed_d;
        end
    end

endmodule

// File: rtl/isc_source.sv
module isc_source
    import isc_pkg::*;
#(
    parameter int PRIO_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    input  logic              rise_i,
    input  logic              cfg_hit_i,
    input  logic              cfg_en_i,
    input  logic              cfg_edge_i,
    input  logic [PRIO_W-1:0] cfg_prio_i,
    input  logic              ack_hit_i,
    input  logic              deact_hit_i,
    output logic              pend_o,
    output logic [PRIO_W-1:0] prio_o
);

    typedef struct packed {
        src_state_e        state;
        logic              latch;
        logic              en;
        logic              edge_md;
        logic [PRIO_W-1:0] prio;
    } src_reg_t;

    src_reg_t src_d, src_q;
    logic     trig;

    always_comb begin
        src_d = src_q;
        trig  = src_q.edge_md ? rise_i : line_i;
        unique case (src_q.state)
            ST_IDLE: begin
                if (src_q.en && trig) begin
                    src_d.state = ST_PEND;
                end
            end
            ST_PEND: begin
                if (ack_hit_i) begin
                    src_d.state = ST_ACT;
                end
            end
            ST_ACT: begin
                if (src_q.edge_md && rise_i) begin
                    src_d.latch = 1'b1;
                end
                if (deact_hit_i) begin
                    src_d.state = (src_q.edge_md && (src_q.latch || rise_i)) ? ST_PEND : ST_IDLE;
                    src_d.latch = 1'b0;
                end
            end
            default: begin
                src_d.state = ST_IDLE;
                src_d.latch = 1'b0;
            end
        endcase
        if (cfg_hit_i) begin
            src_d.en      = cfg_en_i;
            src_d.edge_md = cfg_edge_i;
            src_d.prio    = cfg_prio_i;
            src_d.state   = ST_IDLE;
            src_d.latch   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
        end else begin
            src_q <= src_d;
        end
    end

    assign pend_o = (src_q.state == ST_PEND);
    assign prio_o = src_q.prio;

    AST_CFG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hit_i |=> (src_q.state == ST_IDLE && !src_q.latch)); // R2
    AST_ACK_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q.state == ST_PEND && ack_hit_i && !cfg_hit_i) |=> (src_q.state == ST_ACT)); // R6
    AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q.state == ST_ACT && !deact_hit_i && !cfg_hit_i) |=> (src_q.state == ST_ACT)); // R8
    AST_EDGE_NO_REPEND: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q.state == ST_ACT && src_q.edge_md && deact_hit_i && !src_q.latch && !rise_i && !cfg_hit_i)
        |=> (src_q.state == ST_IDLE)); // R9
    AST_LEVEL_REPEND: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q.state == ST_IDLE && !src_q.edge_md && src_q.en && line_i && !cfg_hit_i)
        |=> (src_q.state == ST_PEND)); // R10
    AST_LATCH_REPEND: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q.state == ST_ACT && src_q.edge_md && src_q.latch && deact_hit_i && !cfg_hit_i)
        |=> (src_q.state == ST_PEND)); // R11

endmodule

// File: rtl/isc_arbiter.sv
module isc_arbiter #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 4,
    parameter int ID_W   = 4
) (
    input  logic [NSRC-1:0]              pend_i,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
    output logic                         win_valid_o,
    output logic [ID_W-1:0]              win_id_o
);

    logic [PRIO_W-1:0] best_prio;

    always_comb begin
        win_valid_o = 1'b0;
        win_id_o    = '1;
        best_prio   = '1;
        for (int i = 0; i < NSRC; i++) begin
            if (pend_i[i] && (!win_valid_o || prio_i[i] < best_prio)) begin
                win_valid_o = 1'b1;
                win_id_o    = ID_W'(i);
                best_prio   = prio_i[i];
            end
        end
    end

endmodule

// File: rtl/irq_state_ctrl.sv
module irq_state_ctrl #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 4,
    parameter int ID_W   = $clog2(NSRC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_line,
    input  logic              cfg_we,
    input  logic [ID_W-1:0]   cfg_id,
    input  logic              cfg_en,
    input  logic              cfg_edge,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              ack_rd,
    output logic [ID_W-1:0]   ack_id,
    input  logic              deact_we,
    input  logic [ID_W-1:0]   deact_id,
    output logic              irq
);

    localparam logic [ID_W-1:0] SPUR_ID = {ID_W{1'b1}};

    logic [NSRC-1:0]              rise;
    logic [NSRC-1:0]              pend;
    logic [NSRC-1:0][PRIO_W-1:0] prio;
    logic                         win_valid;
    logic [ID_W-1:0]              win_id;

    isc_edge_detect #(.NSRC(NSRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (irq_line),
        .rise_o (rise)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic cfg_hit, ack_hit, deact_hit;
        assign cfg_hit   = cfg_we && (cfg_id == ID_W'(g));
        assign ack_hit   = ack_rd && win_valid && (win_id == ID_W'(g));
        assign deact_hit = deact_we && (deact_id == ID_W'(g));

        isc_source #(.PRIO_W(PRIO_W)) u_src (
            .clk         (clk),
            .rst_n       (rst_n),
            .line_i      (irq_line[g]),
            .rise_i      (rise[g]),
            .cfg_hit_i   (cfg_hit),
            .cfg_en_i    (cfg_en),
            .cfg_edge_i  (cfg_edge),
            .cfg_prio_i  (cfg_prio),
            .ack_hit_i   (ack_hit),
            .deact_hit_i (deact_hit),
            .pend_o      (pend[g]),
            .prio_o      (prio[g])
        );
    end

    isc_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
        .pend_i      (pend),
        .prio_i      (prio),
        .win_valid_o (win_valid),
        .win_id_o    (win_id)
    );

    assign irq    = |pend;
    assign ack_id = win_valid ? win_id : SPUR_ID;

    AST_IRQ_HAS_ID: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ack_id != SPUR_ID)); // R4
    AST_QUIET_SPUR: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (ack_id == SPUR_ID)); // R5
    AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && irq) |=> (ack_id != $past(ack_id))); // R6

endmodule

// File: tb/irq_state_ctrl_bench.sv
`timescale 1ns/1ps
module irq_state_ctrl_bench;

    localparam int NSRC   = 8;
    localparam int PRIO_W = 4;
    localparam int ID_W   = 4;
    localparam int SPUR   = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   line = '0;
    logic              cfg_we = 1'b0;
    logic [ID_W-1:0]   cfg_id = '0;
    logic              cfg_en = 1'b0;
    logic              cfg_edge = 1'b0;
    logic [PRIO_W-1:0] cfg_prio = '0;
    logic              ack_rd = 1'b0;
    logic              deact_we = 1'b0;
    logic [ID_W-1:0]   deact_id = '0;
    logic [ID_W-1:0]   ack_id;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_state_ctrl #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_irq_state_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_line (line),
        .cfg_we   (cfg_we),
        .cfg_id   (cfg_id),
        .cfg_en   (cfg_en),
        .cfg_edge (cfg_edge),
        .cfg_prio (cfg_prio),
        .ack_rd   (ack_rd),
        .ack_id   (ack_id),
        .deact_we (deact_we),
        .deact_id (deact_id),
        .irq      (irq)
    );

    // Behavioural reference: 0 idle, 1 pending, 2 active
    int m_st  [NSRC];
    int m_pr  [NSRC];
    bit m_en  [NSRC];
    bit m_edg [NSRC];
    bit m_lat [NSRC];
    bit m_lq  [NSRC];

    function automatic int m_win();
        int best = -1;
        for (int i = 0; i < NSRC; i++) begin
            if (m_st[i] == 1 && (best < 0 || m_pr[i] < m_pr[best])) best = i;
        end
        return best;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSRC; i++) begin
                m_st[i] = 0; m_pr[i] = 0; m_en[i] = 0; m_edg[i] = 0; m_lat[i] = 0; m_lq[i] = 0;
            end
        end else begin
            int w;
            w = m_win();
            for (int i = 0; i < NSRC; i++) begin
                bit rise, trig, ah, dh;
                rise = line[i] && !m_lq[i];
                trig = m_edg[i] ? rise : line[i];
                ah   = ack_rd && (w == i);
                dh   = deact_we && (int'(deact_id) == i);
                if (m_st[i] == 0) begin
                    if (m_en[i] && trig) m_st[i] = 1;
                end else if (m_st[i] == 1) begin
                    if (ah) m_st[i] = 2;
                end else begin
                    if (m_edg[i] && rise) m_lat[i] = 1;
                    if (dh) begin
                        m_st[i]  = (m_edg[i] && m_lat[i]) ? 1 : 0;
                        m_lat[i] = 0;
                    end
                end
                if (cfg_we && int'(cfg_id) == i) begin
                    m_en[i] = cfg_en; m_edg[i] = cfg_edge; m_pr[i] = int'(cfg_prio);
                    m_st[i] = 0; m_lat[i] = 0;
                end
                m_lq[i] = line[i];
            end
        end
    end

    // Every-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int w, eid;
            w   = m_win();
            eid = (w < 0) ? SPUR : w;
            checks++;
            if (irq !== (w >= 0)) begin
                errors++;
                $display("FAIL R4 model irq: actual %0b expected %0b at %0t", irq, (w >= 0), $time);
            end
            checks++;
            if (int'(ack_id) != eid) begin
                errors++;
                $display("FAIL R5 model ack_id: actual %0d expected %0d at %0t", ack_id, eid, $time);
            end
        end
    end

    task automatic check(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic cfg(input int id, input bit en, input bit edg, input int pr);
        cfg_we = 1; cfg_id = ID_W'(id); cfg_en = en; cfg_edge = edg; cfg_prio = PRIO_W'(pr);
        step();
        cfg_we = 0;
    endtask

    task automatic ack();
        ack_rd = 1; step(); ack_rd = 0;
    endtask

    task automatic deact(input int id);
        deact_we = 1; deact_id = ID_W'(id); step(); deact_we = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1;
        step();
        // R1 reset state
        check(int'(irq), 0, "R1 irq after reset");
        check(int'(ack_id), SPUR, "R1 ack_id after reset");

        // R3 disabled source ignores its line
        cfg(1, 0, 0, 0);
        line[1] = 1; step(2);
        check(int'(irq), 0, "R3 disabled line ignored");
        line[1] = 0; step();

        // R5 priority and tie order
        cfg(3, 1, 0, 5);
        cfg(5, 1, 0, 2);
        cfg(6, 1, 0, 2);
        line[3] = 1; line[5] = 1; line[6] = 1; step();
        check(int'(irq), 1, "R4 irq with pending");
        check(int'(ack_id), 5, "R5 lowest value, tie to lower id");
        ack();
        check(int'(ack_id), 6, "R6 ack moves 5 to active");
        ack();
        check(int'(ack_id), 3, "R6 next winner");
        ack();
        check(int'(ack_id), SPUR, "R5 spurious when none pending");
        line[5] = 0; line[6] = 0;
        ack();
        check(int'(irq), 0, "R6 spurious ack no effect");
        deact(2);
        check(int'(irq), 0, "R7 deact of idle source no effect");
        deact(6);
        check(int'(ack_id), SPUR, "R7 deact level low line stays idle");
        // R10 level re-pend
        deact(3);
        check(int'(irq), 0, "R10 idle in cycle after deact");
        step();
        check(int'(ack_id), 3, "R10 level source pending again");
        ack(); line[3] = 0; deact(3); deact(5);
        step();
        check(int'(irq), 0, "R7 all cleared");

        // R9 stuck hazard: held line in edge mode
        cfg(2, 1, 1, 1);
        line[2] = 1; step();
        check(int'(ack_id), 2, "R12 rising edge pends edge source");
        ack();
        step(3);
        check(int'(ack_id), SPUR, "R8 active holds with line high");
        deact(2);
        step(3);
        check(int'(irq), 0, "R9 held line does not re-pend (hazard)");
        line[2] = 0; step();
        line[2] = 1; step();
        check(int'(ack_id), 2, "R9 fresh edge re-pends");
        ack();
        // R11 edge during active is remembered
        line[2] = 0; step();
        line[2] = 1; step();
        check(int'(irq), 0, "R8 edge while active keeps state");
        deact(2);
        check(int'(ack_id), 2, "R11 latched edge pends on deact");
        ack(); line[2] = 0; deact(2);
        check(int'(irq), 0, "R11 cleared");

        // R2 configuration returns a pending source to idle
        cfg(4, 1, 1, 3);
        line[4] = 1; step();
        check(int'(ack_id), 4, "R3 edge source pending");
        cfg(4, 1, 1, 3);
        check(int'(irq), 0, "R2 reconfig clears pending");
        cfg(12, 1, 0, 0);
        step();
        check(int'(irq), 0, "R2 out of range id ignored");
        line[4] = 0; step();

        // R12 already-high line does not count as an edge
        line[7] = 1; step(2);
        cfg(7, 1, 1, 0);
        step(3);
        check(int'(irq), 0, "R12 no edge from steady high");
        cfg(7, 1, 0, 0);
        step();
        check(int'(ack_id), 7, "R3 level mode pends on high line");
        ack(); line[7] = 0; deact(7);

        // Mixed stimulus, compared each cycle against the reference
        for (int c = 0; c < 4000; c++) begin
            line     = NSRC'($urandom);
            cfg_we   = ($urandom % 12) == 0;
            cfg_id   = ID_W'($urandom);
            cfg_en   = ($urandom % 4) != 0;
            cfg_edge = 1'($urandom);
            cfg_prio = PRIO_W'($urandom % 4);
            ack_rd   = ($urandom % 3) == 0;
            deact_we = ($urandom % 3) == 0;
            deact_id = ID_W'($urandom);
            step();
        end
        cfg_we = 0; ack_rd = 0; deact_we = 0;
        step(2);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule